// File: doc/BRIEF.md
# Link Training Hold-Off Controller

This block decides when the link training state machine of a serial-link endpoint may run. Software sets a training-enable bit in a control register. When delay-enable and enhanced mode are both set, a hot reset or link-down event from the link core makes the block clear its training-enable output by itself. The output then stays low until software writes a done bit. In that window software can rewrite configuration registers while the link is still down, so those writes cannot race with a new round of training.

The block also holds a small interrupt status register and an interrupt mask register. A reset event or a link-up change event sets its own sticky status bit. The interrupt output is raised when any set status bit is enabled in the mask. Software clears status bits by reading the register and writing the same value back. The control register and the mask register use a masked write format: the upper half of the write word enables the matching bits in the lower half. Everything sits behind a simple single-cycle register bus with a combinational read path.

Top module: `ltho_ctrl`

## Requirements
- R1: After reset is released, train_en_o and irq_o are 0 and the control, status and mask registers all read 0.
- R2: The control register is at address 0x180. A write changes lower bit n only when write-data bit n+16 is 1. Bit 0 is the software training enable, bit 1 is delay-enable and bit 4 is enhanced mode. All other bits, including the done bit 3, read back as 0.
- R3: While delay-enable or enhanced mode is 0, train_en_o equals control bit 0 from the cycle after the write, and reset events have no effect on it.
- R4: While delay-enable and enhanced mode are both 1, a hot_reset_i or link_down_i pulse drives train_en_o low from the next cycle, and it stays low for as long as no done write arrives.
- R5: A control write with bit 3 and bit 19 both set releases the hold. train_en_o returns to control bit 0 in the next cycle. The done bit does not stay set, so a later event starts a new hold.
- R6: When a reset event and a done write occur in the same cycle, the event wins and the hold stays in force.
- R7: Clearing delay-enable or enhanced mode during a hold releases it. train_en_o follows control bit 0 from the next cycle.
- R8: The status register is at address 0x010. Bit 0 is set by hot_reset_i or link_down_i and bit 1 by link_up_chg_i. Both bits are sticky.
- R9: A plain write to the status register clears each bit written as 1 and leaves the others unchanged. A set event in the same cycle wins over the clear.
- R10: The mask register is at address 0x014, with bits 1:0 written in the masked format of R2. irq_o is 1 exactly when some status bit and its mask bit are both 1, and it falls in the cycle after the clearing write.
- R11: Writes to any other address change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register byte address, used for both read and write |
| reg_wdata_i | input | 32 | Write data; upper half is the write enable for the control and mask registers |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| hot_reset_i | input | 1 | Hot reset event pulse from the link core |
| link_down_i | input | 1 | Link-down reset event pulse from the link core |
| link_up_chg_i | input | 1 | Link-up change event pulse |
| train_en_o | output | 1 | Permission for the training state machine to run |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 12-bit address space and the three default register offsets. At this size it can try every pairing of the five low control data bits with every pattern of their write enables, and every configuration of software enable, delay-enable and enhanced mode against each kind of reset event. It can also write all ones to every word address outside the register map. Same-cycle collisions are driven on purpose: an event against a done write, and a status set against a status clear.

// File: rtl/ltho_pkg.sv
package ltho_pkg;
  localparam int HALF_W   = 16;
  localparam int NUM_SRC  = 2;
  localparam int BIT_SW   = 0;
  localparam int BIT_DLY  = 1;
  localparam int BIT_DONE = 3;
  localparam int BIT_ENH  = 4;
  localparam int SRC_RST  = 0;
  localparam int SRC_LUP  = 1;
  localparam logic [HALF_W-1:0] CTRL_KEEP =
    HALF_W'((1 << BIT_SW) | (1 << BIT_DLY) | (1 << BIT_ENH));

  function automatic logic [HALF_W-1:0] masked_upd(
    input logic [HALF_W-1:0] old_v,
    input logic [HALF_W-1:0] new_v,
    input logic [HALF_W-1:0] en_v
  );
    return (old_v & ~en_v) | (new_v & en_v);
  endfunction
endpackage

// File: rtl/ltho_regbus.sv
module ltho_regbus
  import ltho_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h180,
  parameter logic [ADDR_W-1:0] ISTAT_OFS = 'h010,
  parameter logic [ADDR_W-1:0] IMASK_OFS = 'h014
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               we_i,
  input  logic [HALF_W-1:0]  ctrl_rd_i,
  input  logic [NUM_SRC-1:0] istat_rd_i,
  input  logic [NUM_SRC-1:0] imask_rd_i,
  output logic               ctrl_wr_o,
  output logic               istat_wr_o,
  output logic               imask_wr_o,
  output logic [HALF_W-1:0]  wval_o,
  output logic [HALF_W-1:0]  wen_o,
  output logic [31:0]        rdata_o
);
  logic hit_ctrl, hit_istat, hit_imask;

  assign hit_ctrl  = (addr_i == CTRL_OFS);
  assign hit_istat = (addr_i == ISTAT_OFS);
  assign hit_imask = (addr_i == IMASK_OFS);

  assign ctrl_wr_o  = we_i & hit_ctrl;
  assign istat_wr_o = we_i & hit_istat;
  assign imask_wr_o = we_i & hit_imask;
  assign wval_o     = wdata_i[HALF_W-1:0];
  assign wen_o      = wdata_i[2*HALF_W-1:HALF_W];

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)       rdata_o[HALF_W-1:0]  = ctrl_rd_i;
    else if (hit_istat) rdata_o[NUM_SRC-1:0] = istat_rd_i;
    else if (hit_imask) rdata_o[NUM_SRC-1:0] = imask_rd_i;
  end
endmodule

// File: rtl/ltho_hold.sv
module ltho_hold
  import ltho_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [HALF_W-1:0] wval_i,
  input  logic [HALF_W-1:0] wen_i,
  input  logic              evt_i,
  output logic [HALF_W-1:0] ctrl_rd_o,
  output logic              armed_o,
  output logic              hold_o,
  output logic              done_o,
  output logic              train_en_o
);
  logic [HALF_W-1:0] ctrl_q;
  logic              hold_q;

  assign armed_o = ctrl_q[BIT_DLY] & ctrl_q[BIT_ENH];
  assign done_o  = ctrl_wr_i & wen_i[BIT_DONE] & wval_i[BIT_DONE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_i) begin
      ctrl_q <= masked_upd(ctrl_q, wval_i, wen_i) & CTRL_KEEP;
    end
  end

  // event beats done; losing the arm drops any pending hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= 1'b0;
    else if (evt_i && armed_o)   hold_q <= 1'b1;
    else if (done_o || !armed_o) hold_q <= 1'b0;
  end

  assign hold_o     = hold_q;
  assign ctrl_rd_o  = ctrl_q;
  assign train_en_o = ctrl_q[BIT_SW] & ~(hold_q & armed_o);
endmodule

// File: rtl/ltho_irq.sv
module ltho_irq
  import ltho_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               istat_wr_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               imask_wr_i,
  input  logic [NUM_SRC-1:0] mval_i,
  input  logic [NUM_SRC-1:0] men_i,
  output logic [NUM_SRC-1:0] istat_o,
  output logic [NUM_SRC-1:0] imask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] istat_q, imask_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) istat_q[i] <= 1'b0;
      else         istat_q[i] <= set_i[i] | (istat_q[i] & ~(istat_wr_i & clr_i[i]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     imask_q[i] <= 1'b0;
      else if (imask_wr_i && men_i[i]) imask_q[i] <= mval_i[i];
    end
  end

  assign istat_o = istat_q;
  assign imask_o = imask_q;
  assign irq_o   = |(istat_q & imask_q);
endmodule

// File: rtl/ltho_ctrl.sv
module ltho_ctrl
  import ltho_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h180,
  parameter logic [ADDR_W-1:0] ISTAT_OFS = 'h010,
  parameter logic [ADDR_W-1:0] IMASK_OFS = 'h014
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              hot_reset_i,
  input  logic              link_down_i,
  input  logic              link_up_chg_i,
  output logic              train_en_o,
  output logic              irq_o
);
  logic               ctrl_wr, istat_wr, imask_wr;
  logic [HALF_W-1:0]  wval, wen, ctrl_rd;
  logic [NUM_SRC-1:0] istat_q, imask_q, set_vec;
  logic               evt, armed, hold_q, done_pulse;

  assign evt              = hot_reset_i | link_down_i;
  assign set_vec[SRC_RST] = evt;
  assign set_vec[SRC_LUP] = link_up_chg_i;

  ltho_regbus #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS),
    .ISTAT_OFS(ISTAT_OFS), .IMASK_OFS(IMASK_OFS)
  ) u_bus (
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i),
    .ctrl_rd_i(ctrl_rd), .istat_rd_i(istat_q), .imask_rd_i(imask_q),
    .ctrl_wr_o(ctrl_wr), .istat_wr_o(istat_wr), .imask_wr_o(imask_wr),
    .wval_o(wval), .wen_o(wen), .rdata_o(reg_rdata_o)
  );

  ltho_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr),
    .wval_i(wval), .wen_i(wen), .evt_i(evt),
    .ctrl_rd_o(ctrl_rd), .armed_o(armed), .hold_o(hold_q),
    .done_o(done_pulse), .train_en_o(train_en_o)
  );

  ltho_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec),
    .istat_wr_i(istat_wr), .clr_i(wval[NUM_SRC-1:0]),
    .imask_wr_i(imask_wr), .mval_i(wval[NUM_SRC-1:0]),
    .men_i(wen[NUM_SRC-1:0]),
    .istat_o(istat_q), .imask_o(imask_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/ltho_ctrl_chk.sv
module ltho_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic evt,
  input logic armed,
  input logic hold_q,
  input logic done_pulse,
  input logic train_en_o,
  input logic irq_o,
  input logic ist0,
  input logic msk0,
  input logic clr0
);
  assert_hold_on_evt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && armed |=> !train_en_o && hold_q);

  assert_hold_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && armed && !done_pulse |=> hold_q);

  assert_done_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse && !evt |=> !hold_q);

  assert_evt_beats_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse && evt && armed |=> hold_q);

  assert_status_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> ist0);

  assert_status_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr0 && !evt |=> !ist0);

  assert_irq_raise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ist0 && msk0 |-> irq_o);
endmodule

bind ltho_ctrl ltho_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt(evt), .armed(armed),
  .hold_q(hold_q), .done_pulse(done_pulse), .train_en_o(train_en_o),
  .irq_o(irq_o), .ist0(istat_q[0]), .msk0(imask_q[0]),
  .clr0(istat_wr & wval[0])
);

// File: tb/ltho_ctrl_tb.sv
module ltho_ctrl_tb;
  localparam logic [11:0] A_CTRL  = 12'h180;
  localparam logic [11:0] A_ISTAT = 12'h010;
  localparam logic [11:0] A_IMASK = 12'h014;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        we = 1'b0, hr = 1'b0, ld = 1'b0, lu = 1'b0;
  logic        train_en, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  logic m_sw = 0, m_dly = 0, m_enh = 0, m_hold = 0;
  logic [1:0] m_ist = '0, m_msk = '0;

  always #5 clk = ~clk;

  ltho_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .hot_reset_i(hr), .link_down_i(ld),
    .link_up_chg_i(lu), .train_en_o(train_en), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_ctrl();
    return {27'd0, m_enh, 2'b00, m_dly, m_sw};
  endfunction

  // one clock of stimulus; model updated per the requirements; outputs checked after the edge
  task automatic step(input string req, input logic h, input logic d, input logic u,
                      input logic w, input logic [11:0] a, input logic [31:0] dat);
    logic evt, armed, done;
    @(negedge clk);
    hr = h; ld = d; lu = u; we = w; addr = a; wdata = dat;
    evt   = h | d;
    armed = m_enh & m_dly;
    done  = w && a == A_CTRL && dat[19] && dat[3];
    if (evt && armed)       m_hold = 1'b1;
    else if (done || !armed) m_hold = 1'b0;
    if (w && a == A_CTRL) begin
      if (dat[16]) m_sw  = dat[0];
      if (dat[17]) m_dly = dat[1];
      if (dat[20]) m_enh = dat[4];
    end
    for (int i = 0; i < 2; i++) begin
      logic setb;
      setb = (i == 0) ? evt : u;
      m_ist[i] = setb | (m_ist[i] & ~(w && a == A_ISTAT && dat[i]));
      if (w && a == A_IMASK && dat[16+i]) m_msk[i] = dat[i];
    end
    @(negedge clk);
    hr = 0; ld = 0; lu = 0; we = 0;
    chk({req, " train_en"}, 32'(train_en), 32'(m_sw & ~(m_hold & m_enh & m_dly)));
    chk({req, " irq"}, 32'(irq), 32'(|(m_ist & m_msk)));
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(input string req, input logic [11:0] a, input logic [31:0] dat);
    step(req, 0, 0, 0, 1, a, dat);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 train_en in reset", 32'(train_en), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 train_en", 32'(train_en), 0);
    chk("R1 irq", 32'(irq), 0);
    rd("R1 ctrl", A_CTRL, 0);
    rd("R1 istat", A_ISTAT, 0);
    rd("R1 imask", A_IMASK, 0);

    // R2 masked write sweep over low five bits
    for (int v = 0; v < 32; v++)
      for (int e = 0; e < 32; e++) begin
        wr("R2 sweep", A_CTRL, {11'd0, 5'(e), 11'd0, 5'(v)});
        rd("R2 readback", A_CTRL, m_ctrl());
      end
    wr("R2 all ones", A_CTRL, 32'hFFFF_FFFF);
    rd("R2 reserved zero", A_CTRL, 32'h13);
    wr("R2 no enable", A_CTRL, 32'h0000_0000);
    rd("R2 unchanged", A_CTRL, 32'h13);

    // R3/R4/R5: every config against every event kind
    for (int cfg = 0; cfg < 8; cfg++)
      for (int ev = 1; ev < 4; ev++) begin
        wr("R3 cfg", A_CTRL, {16'h0013, 11'd0, cfg[2], 2'b00, cfg[1], cfg[0]});
        step(cfg[2] && cfg[1] ? "R4 event hold" : "R3 event ignored",
             ev[0], ev[1], 0, 0, A_CTRL, 0);
        step("R4 hold persists", 0, 0, 0, 0, A_CTRL, 0);
        wr("R5 done release", A_CTRL, 32'h0008_0008);
        rd("R5 done reads 0", A_CTRL, m_ctrl());
        wr("R9 clear", A_ISTAT, 32'h3);
      end

    // R5 re-hold after release
    wr("R5 arm", A_CTRL, 32'h0013_0013);
    step("R5 first hold", 1, 0, 0, 0, A_CTRL, 0);
    wr("R5 release", A_CTRL, 32'h0008_0008);
    chk("R5 released", 32'(train_en), 1);
    step("R5 second hold", 0, 1, 0, 0, A_CTRL, 0);
    chk("R5 rehold low", 32'(train_en), 0);

    // R6 event and done together
    step("R6 collide", 1, 0, 0, 1, A_CTRL, 32'h0008_0008);
    chk("R6 still held", 32'(train_en), 0);
    wr("R6 done", A_CTRL, 32'h0008_0008);
    chk("R6 released", 32'(train_en), 1);

    // R7 disarm during hold
    step("R7 hold", 1, 0, 0, 0, A_CTRL, 0);
    wr("R7 clear dly", A_CTRL, 32'h0002_0000);
    chk("R7 released", 32'(train_en), 1);
    wr("R7 rearm", A_CTRL, 32'h0012_0012);
    step("R7 hold2", 0, 1, 0, 0, A_CTRL, 0);
    wr("R7 clear enh", A_CTRL, 32'h0010_0000);
    chk("R7 released enh", 32'(train_en), 1);
    wr("R9 clear", A_ISTAT, 32'h3);

    // R8/R9/R10: every mask against every source pattern
    for (int m = 0; m < 4; m++)
      for (int s = 1; s < 4; s++) begin
        wr("R10 mask", A_IMASK, {16'h0003, 14'd0, 2'(m)});
        rd("R10 mask read", A_IMASK, 32'(m));
        step("R8 set", s[0], 0, s[1], 0, A_CTRL, 0);
        rd("R8 status", A_ISTAT, 32'(m_ist));
        step("R8 sticky", 0, 0, 0, 0, A_CTRL, 0);
        wr("R9 w1c", A_ISTAT, 32'(m_ist));
        rd("R9 cleared", A_ISTAT, 0);
        chk("R10 irq drop", 32'(irq), 0);
      end
    step("R8 link_down", 0, 1, 0, 0, A_CTRL, 0);
    rd("R8 link_down sets", A_ISTAT, 1);
    step("R9 set wins", 1, 0, 1, 1, A_ISTAT, 32'h3);
    rd("R9 set wins read", A_ISTAT, 3);
    wr("R9 partial", A_ISTAT, 32'h2);
    rd("R9 partial read", A_ISTAT, 1);
    wr("R10 mask no en", A_IMASK, 32'h0000_0000);
    rd("R10 mask kept", A_IMASK, 32'(m_msk));
    wr("R9 clear", A_ISTAT, 32'h3);

    // R11 writes elsewhere
    wr("R11 set", A_CTRL, 32'h0013_0001);
    wr("R11 mask", A_IMASK, 32'h0003_0002);
    for (int a = 0; a < 4096; a += 4) begin
      if (a != 'h180 && a != 'h010 && a != 'h014)
        wr("R11 stray", 12'(a), 32'hFFFF_FFFF);
    end
    rd("R11 ctrl", A_CTRL, 32'h1);
    rd("R11 istat", A_ISTAT, 0);
    rd("R11 imask", A_IMASK, 32'h2);
    chk("R11 train_en", 32'(train_en), 1);

    finish_run();
  end
endmodule